// File: doc/BRIEF.md
# Shared DRAM Nibble-Access Sequencer

This block shares one DRAM that is four bits wide and has a multiplexed address bus between a video fetch engine and a CPU. It runs a ring of eight one-hot slots that repeats without stopping. In each pass it puts a row address on the bus and strobes the row select. It then puts out two column addresses one after the other and strobes the column select for each. The DRAM returns one nibble per column, and the two nibbles make up one byte.

A request input is sampled at the start of each pass and decides who owns the pass. When video owns it, the pixel address is used and the two nibbles are joined into a byte for the pixel path. The high nibble is read in the middle of the pass and the low nibble in the first slot of the next pass. When the CPU owns it, the CPU address is used, and the same two read slots raise a high-half strobe and then a low-half strobe to the CPU, each carrying the nibble that was read. The low-half strobe comes with a CPU clock tick.

The pixel column pointer is told to step whenever video wants the pass. This happens even when an interrupt holds video off the bus, so the pointer keeps pace with the beam.

Top module: `nds_sequencer`

## Requirements
- R1: After reset `slot` is 8'h01. Each clock the set bit moves one place up, and bit 7 wraps back to bit 0, so exactly one bit is set at all times.
- R2: On the clock edge where `slot` is 8'h01, both `dram_row_sel` and `dram_col_sel` drop to 0. They are visible low from the next cycle.
- R3: On the clock edge where `slot` is 8'h02, `dram_addr` takes the row field, which is bits [15:8] of the source address, zero-extended to 9 bits. The source is `pix_addr` if the pass is video-owned and `cpu_addr` otherwise.
- R4: On the clock edge where `slot` is 8'h04, `dram_row_sel` rises. On the same edge `dram_addr` becomes the first column, {source[7:0], 1'b0}.
- R5: `dram_col_sel` rises on the 8'h08 edge. On the 8'h20 edge it falls and `dram_addr` becomes the second column, {source[7:0], 1'b1}. It rises again on the 8'h40 edge. While it stays high, `dram_addr` does not change.
- R6: In a video-owned pass, the nibble present on `dram_dq` at the 8'h20 edge becomes `pix_byte[7:4]`. The nibble present at the next 8'h01 edge becomes `pix_byte[3:0]`. `pix_byte_vld` pulses for one cycle after that 8'h01 edge.
- R7: In a CPU-owned pass, `cpu_hi_stb` pulses after the 8'h20 edge, with `cpu_nib` holding the nibble read at that edge. At the next 8'h01 edge, `cpu_lo_stb` and `cpu_clk_tick` pulse together, with `cpu_nib` holding the second nibble. A low strobe is also given on any 8'h01 edge that does not follow a video-owned pass, including the first one after reset.
- R8: `pix_step` pulses after the 8'h80 edge whenever `video_want` was 1 at the start of the pass. This holds even when `video_req` was 0, and in that case the CPU owns the pass.
- R9: `video_req` and `video_want` are sampled only on the 8'h01 edge. The source address is sampled only on the 8'h02 edge. Changes to these inputs after those edges have no effect within the pass.
- R10: While `rst_n` is low, the strobes, selects, `dram_addr`, `pix_byte` and `cpu_nib` are all 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| video_req | input | 1 | Video takes this pass (sampled at slot 8'h01) |
| video_want | input | 1 | Video would take this pass if not held off |
| pix_addr | input | 16 | Pixel byte address |
| cpu_addr | input | 16 | CPU byte address |
| dram_dq | input | 4 | Nibble returned by the DRAM |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_row_sel | output | 1 | Row select, active high |
| dram_col_sel | output | 1 | Column select, active high |
| slot | output | 8 | One-hot current slot |
| pix_byte | output | 8 | Assembled pixel byte |
| pix_byte_vld | output | 1 | One-cycle pulse: pix_byte is new |
| pix_step | output | 1 | Advance the pixel column pointer |
| cpu_clk_tick | output | 1 | CPU clock update pulse |
| cpu_hi_stb | output | 1 | CPU high-half transfer pulse |
| cpu_lo_stb | output | 1 | CPU low-half transfer pulse |
| cpu_nib | output | 4 | Nibble carried by the CPU strobes |

## Verification
The assertions assume that `video_req` is never 1 at the 8'h01 edge while `video_want` is 0, because video cannot own a pass it does not want. The stimulus only ever applies request pairs that meet this rule, and one of those pairs is the held-off case (0, 1). The stimulus changes the requests and both addresses right after they are sampled. This shows that the sampling points hold and that the strobe order does not depend on inputs held steady.

// File: rtl/nds_pkg.sv
package nds_pkg;
  localparam int unsigned NPH = 8;
  // slot indices; the order is the access sequence itself
  localparam int unsigned S_WRAP = 0;  // finish low read, drop selects
  localparam int unsigned S_ROW  = 1;  // drive row
  localparam int unsigned S_RAS  = 2;  // row select, drive column 0
  localparam int unsigned S_CAS0 = 3;  // column select
  localparam int unsigned S_HOLD = 4;
  localparam int unsigned S_COL1 = 5;  // read high, drive column 1
  localparam int unsigned S_CAS1 = 6;  // column select again
  localparam int unsigned S_END  = 7;  // step pointer, mark pending
  typedef logic [NPH-1:0] slot_t;
endpackage

// File: rtl/nds_slot_ring.sv
module nds_slot_ring
  import nds_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output slot_t slot_q
);
  slot_t slot_d;

  always_comb begin
    slot_d = {slot_q[NPH-2:0], slot_q[NPH-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= slot_t'(1);
    else        slot_q <= slot_d;
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_q) == 1);
  p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q[NPH-1] |=> slot_q[0]);
endmodule

// File: rtl/nds_addr_drive.sv
module nds_addr_drive
  import nds_pkg::*;
#(
  parameter int unsigned ROW_W = 8,
  parameter int unsigned COL_W = 8,
  localparam int unsigned ADDR_W = ROW_W + COL_W,
  localparam int unsigned DA_W = (ROW_W > COL_W + 1) ? ROW_W : COL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_t             slot_q,
  input  logic              own_video,
  input  logic [ADDR_W-1:0] pix_addr,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [DA_W-1:0]   dram_addr,
  output logic              row_sel,
  output logic              col_sel
);
  logic [ADDR_W-1:0] pick;
  logic [ADDR_W-1:0] src_q, src_d;
  logic [DA_W-1:0]   addr_d;
  logic              row_d, col_d;
  logic              src_en;

  assign pick   = own_video ? pix_addr : cpu_addr;
  assign src_en = slot_q[S_ROW];

  always_comb begin
    src_d  = src_en ? pick : src_q;
    addr_d = dram_addr;
    row_d  = row_sel;
    col_d  = col_sel;
    if (slot_q[S_WRAP]) begin
      row_d = 1'b0;
      col_d = 1'b0;
    end
    if (slot_q[S_ROW]) begin
      addr_d = DA_W'(pick[ADDR_W-1 -: ROW_W]);
    end
    if (slot_q[S_RAS]) begin
      row_d  = 1'b1;
      addr_d = DA_W'({src_q[COL_W-1:0], 1'b0});
    end
    if (slot_q[S_CAS0]) begin
      col_d = 1'b1;
    end
    if (slot_q[S_COL1]) begin
      col_d  = 1'b0;
      addr_d = DA_W'({src_q[COL_W-1:0], 1'b1});
    end
    if (slot_q[S_CAS1]) begin
      col_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q     <= '0;
      dram_addr <= '0;
      row_sel   <= 1'b0;
      col_sel   <= 1'b0;
    end else begin
      src_q     <= src_d;
      dram_addr <= addr_d;
      row_sel   <= row_d;
      col_sel   <= col_d;
    end
  end

  p_drop_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q[S_WRAP] |=> (!row_sel && !col_sel));
  p_col_under_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    col_sel |-> row_sel);
  p_col_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_sel && $past(col_sel)) |-> $stable(dram_addr));
  p_row_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_sel) |-> slot_q[S_CAS0]);
endmodule

// File: rtl/nds_nibble_path.sv
module nds_nibble_path
  import nds_pkg::*;
#(
  parameter int unsigned NIB_W = 4,
  localparam int unsigned BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_t             slot_q,
  input  logic              own_video,
  input  logic              want_video,
  input  logic [NIB_W-1:0]  dq,
  output logic [BYTE_W-1:0] pix_byte,
  output logic              pix_vld,
  output logic              pix_step,
  output logic              cpu_tick,
  output logic              cpu_hi,
  output logic              cpu_lo,
  output logic [NIB_W-1:0]  cpu_nib
);
  logic [NIB_W-1:0]  hi_q, hi_d;
  logic              pend_q, pend_d;
  logic [BYTE_W-1:0] byte_d;
  logic [NIB_W-1:0]  nib_d;
  logic              vld_d, step_d, tick_d, hi_stb_d, lo_stb_d;

  always_comb begin
    hi_d     = hi_q;
    pend_d   = pend_q;
    byte_d   = pix_byte;
    nib_d    = cpu_nib;
    vld_d    = 1'b0;
    step_d   = 1'b0;
    tick_d   = 1'b0;
    hi_stb_d = 1'b0;
    lo_stb_d = 1'b0;
    if (slot_q[S_WRAP]) begin
      pend_d = 1'b0;
      if (pend_q) begin
        byte_d = {hi_q, dq};
        vld_d  = 1'b1;
      end else begin
        nib_d    = dq;
        lo_stb_d = 1'b1;
        tick_d   = 1'b1;
      end
    end
    if (slot_q[S_COL1]) begin
      if (own_video) begin
        hi_d = dq;
      end else begin
        nib_d    = dq;
        hi_stb_d = 1'b1;
      end
    end
    if (slot_q[S_END]) begin
      step_d = want_video;
      pend_d = own_video;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= '0;
      pend_q   <= 1'b0;
      pix_byte <= '0;
      cpu_nib  <= '0;
      pix_vld  <= 1'b0;
      pix_step <= 1'b0;
      cpu_tick <= 1'b0;
      cpu_hi   <= 1'b0;
      cpu_lo   <= 1'b0;
    end else begin
      hi_q     <= hi_d;
      pend_q   <= pend_d;
      pix_byte <= byte_d;
      cpu_nib  <= nib_d;
      pix_vld  <= vld_d;
      pix_step <= step_d;
      cpu_tick <= tick_d;
      cpu_hi   <= hi_stb_d;
      cpu_lo   <= lo_stb_d;
    end
  end

  p_vld_or_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_vld && cpu_lo));
  p_vld_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |-> slot_q[S_ROW]);
  p_pend_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q[S_WRAP] |=> !pend_q);
  p_hi_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hi |-> slot_q[S_CAS1]);
  p_lo_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_lo |-> cpu_tick);
  p_step_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_step |-> slot_q[S_WRAP]);
endmodule

// File: rtl/nds_sequencer.sv
module nds_sequencer
  import nds_pkg::*;
#(
  parameter int unsigned ROW_W = 8,
  parameter int unsigned COL_W = 8,
  parameter int unsigned NIB_W = 4,
  localparam int unsigned ADDR_W = ROW_W + COL_W,
  localparam int unsigned DA_W = (ROW_W > COL_W + 1) ? ROW_W : COL_W + 1,
  localparam int unsigned BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              video_req,
  input  logic              video_want,
  input  logic [ADDR_W-1:0] pix_addr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [NIB_W-1:0]  dram_dq,
  output logic [DA_W-1:0]   dram_addr,
  output logic              dram_row_sel,
  output logic              dram_col_sel,
  output logic [NPH-1:0]    slot,
  output logic [BYTE_W-1:0] pix_byte,
  output logic              pix_byte_vld,
  output logic              pix_step,
  output logic              cpu_clk_tick,
  output logic              cpu_hi_stb,
  output logic              cpu_lo_stb,
  output logic [NIB_W-1:0]  cpu_nib
);
  slot_t slot_q;
  logic  own_q, own_d, want_q, want_d;
  logic  grant_en;

  nds_slot_ring u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .slot_q (slot_q)
  );

  assign grant_en = slot_q[S_WRAP];

  always_comb begin
    own_d  = grant_en ? video_req  : own_q;
    want_d = grant_en ? video_want : want_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= 1'b0;
      want_q <= 1'b0;
    end else begin
      own_q  <= own_d;
      want_q <= want_d;
    end
  end

  nds_addr_drive #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_q    (slot_q),
    .own_video (own_q),
    .pix_addr  (pix_addr),
    .cpu_addr  (cpu_addr),
    .dram_addr (dram_addr),
    .row_sel   (dram_row_sel),
    .col_sel   (dram_col_sel)
  );

  nds_nibble_path #(.NIB_W(NIB_W)) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_q     (slot_q),
    .own_video  (own_q),
    .want_video (want_q),
    .dq         (dram_dq),
    .pix_byte   (pix_byte),
    .pix_vld    (pix_byte_vld),
    .pix_step   (pix_step),
    .cpu_tick   (cpu_clk_tick),
    .cpu_hi     (cpu_hi_stb),
    .cpu_lo     (cpu_lo_stb),
    .cpu_nib    (cpu_nib)
  );

  assign slot = slot_q;

  // input rule: video never owns a pass it does not want
  p_req_needs_want_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q[S_WRAP] && video_req) |-> video_want);
  p_own_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_q[S_ROW] |-> $stable(own_q));
endmodule

// File: tb/nds_sequencer_tb.sv
module nds_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        video_req = 1'b0, video_want = 1'b0;
  logic [15:0] pix_addr = '0, cpu_addr = '0;
  logic [3:0]  dram_dq;
  logic [8:0]  dram_addr;
  logic        dram_row_sel, dram_col_sel;
  logic [7:0]  slot;
  logic [7:0]  pix_byte;
  logic        pix_byte_vld, pix_step, cpu_clk_tick, cpu_hi_stb, cpu_lo_stb;
  logic [3:0]  cpu_nib;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nds_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .video_req(video_req), .video_want(video_want),
    .pix_addr(pix_addr), .cpu_addr(cpu_addr), .dram_dq(dram_dq),
    .dram_addr(dram_addr), .dram_row_sel(dram_row_sel), .dram_col_sel(dram_col_sel),
    .slot(slot), .pix_byte(pix_byte), .pix_byte_vld(pix_byte_vld),
    .pix_step(pix_step), .cpu_clk_tick(cpu_clk_tick), .cpu_hi_stb(cpu_hi_stb),
    .cpu_lo_stb(cpu_lo_stb), .cpu_nib(cpu_nib)
  );

  function automatic int nib_at(int r, int c);
    return (r * 7 + c * 3 + (c >> 5)) & 15;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural DRAM: strobe edge latches the address seen one slot earlier
  int a_last = 0, row_l = 0, col_l = 0;
  bit ras_seen = 0, cas_seen = 0, cas_l = 0;
  assign dram_dq = cas_l ? 4'(nib_at(row_l, col_l)) : 4'h0;

  always @(negedge clk) begin
    if (dram_row_sel && !ras_seen) row_l = a_last;
    ras_seen = dram_row_sel;
    if (dram_col_sel && !cas_seen) begin col_l = a_last; cas_l = 1; end
    if (!dram_col_sel) cas_l = 0;
    cas_seen = dram_col_sel;
    a_last = int'(dram_addr);
  end

  // reference model, stepped on each rising edge
  int k = 0;
  bit m_on = 0, m_first = 1, m_own = 0, m_want = 0, m_pend = 0;
  int m_a = 0;
  int e_slot = 1, e_addr = 0, e_byte = 0, e_nib = 0;
  bit e_ras = 0, e_cas = 0, e_vld = 0, e_step = 0, e_tick = 0, e_hi = 0, e_lo = 0;
  int n_vld = 0, n_step = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      k = 0; m_first = 1; m_pend = 0; m_on = 0;
    end else begin
      m_on = 1;
      e_vld = 0; e_step = 0; e_tick = 0; e_hi = 0; e_lo = 0;
      case (k)
        0: begin
          e_ras = 0; e_cas = 0;
          if (m_pend) begin
            e_vld  = 1;
            e_byte = (nib_at(m_a >> 8, (m_a & 255) * 2) << 4)
                   | nib_at(m_a >> 8, (m_a & 255) * 2 + 1);
          end else begin
            e_lo = 1; e_tick = 1;
            e_nib = m_first ? 0 : nib_at(m_a >> 8, (m_a & 255) * 2 + 1);
          end
          m_pend = 0; m_first = 0;
          m_own = video_req; m_want = video_want;
        end
        1: begin
          m_a = m_own ? int'(pix_addr) : int'(cpu_addr);
          e_addr = m_a >> 8;
        end
        2: begin e_ras = 1; e_addr = (m_a & 255) * 2; end
        3: e_cas = 1;
        5: begin
          e_cas = 0; e_addr = (m_a & 255) * 2 + 1;
          if (!m_own) begin e_hi = 1; e_nib = nib_at(m_a >> 8, (m_a & 255) * 2); end
        end
        6: e_cas = 1;
        7: begin e_step = m_want; m_pend = m_own; end
        default: ;
      endcase
      k = (k + 1) % 8;
      e_slot = 1 << k;
    end
  end

  always @(negedge clk) begin
    if (rst_n && m_on) begin
      chk("R1 slot", int'(slot), e_slot);
      chk("R2/R4 row_sel", int'(dram_row_sel), int'(e_ras));
      chk("R5 col_sel", int'(dram_col_sel), int'(e_cas));
      chk("R3/R4/R5/R9 dram_addr", int'(dram_addr), e_addr);
      chk("R6 pix_byte_vld", int'(pix_byte_vld), int'(e_vld));
      if (e_vld) chk("R6 pix_byte", int'(pix_byte), e_byte);
      chk("R7 cpu_hi_stb", int'(cpu_hi_stb), int'(e_hi));
      chk("R7 cpu_lo_stb", int'(cpu_lo_stb), int'(e_lo));
      chk("R7 cpu_clk_tick", int'(cpu_clk_tick), int'(e_tick));
      if (e_hi || e_lo) chk("R7 cpu_nib", int'(cpu_nib), e_nib);
      chk("R8 pix_step", int'(pix_step), int'(e_step));
      if (pix_byte_vld) n_vld++;
      if (pix_step) n_step++;
    end
  end

  // one pass; requests and addresses are scrambled right after sampling (R9)
  task automatic run_pass(bit req, bit want, logic [15:0] pa, logic [15:0] ca);
    @(negedge clk);
    while (slot != 8'h01) @(negedge clk);
    video_req = req; video_want = want; pix_addr = pa; cpu_addr = ca;
    @(negedge clk);
    video_req = 0; video_want = 0;
    @(negedge clk);
    pix_addr = ~pa; cpu_addr = ~ca;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset values
    chk("R10 slot", int'(slot), 1);
    chk("R10 selects", int'({dram_row_sel, dram_col_sel}), 0);
    chk("R10 dram_addr", int'(dram_addr), 0);
    chk("R10 strobes", int'({pix_byte_vld, pix_step, cpu_clk_tick, cpu_hi_stb, cpu_lo_stb}), 0);
    chk("R10 data", int'({pix_byte, cpu_nib}), 0);
    rst_n = 1;
    run_pass(1, 1, 16'h12A5, 16'h0F0F);
    run_pass(1, 1, 16'hFF00, 16'h1111);
    run_pass(0, 0, 16'h2222, 16'h3C7E);
    run_pass(0, 1, 16'h4444, 16'h8001);   // held off, still steps (R8)
    run_pass(1, 1, 16'h00FF, 16'h0000);
    run_pass(0, 0, 16'h0000, 16'hFFFF);
    run_pass(0, 0, 16'h5555, 16'h7E81);
    run_pass(1, 1, 16'hA5A5, 16'h0000);
    run_pass(1, 1, 16'h5A5B, 16'h0000);
    run_pass(0, 1, 16'h9999, 16'hC3C3);
    run_pass(0, 0, 16'h0000, 16'h0000);
    repeat (10) @(negedge clk);
    chk("R6 byte count", n_vld, 5);
    chk("R8 step count", n_step, 7);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule